// File: doc/BRIEF.md
# Double-Buffered Bit-Level Crossbar Switch

This block is a non-blocking crossbar for single-bit signals. Each of its output ports is driven by exactly one chosen input port. Any input can feed any number of outputs at the same time. Output routing never restricts which input another output may pick. The data path is purely combinational, from input port through the selected cell to output port.

Routing is held in two banks of configuration cells. A synchronous configuration bus writes new routing into a staging (shadow) bank while the live (active) bank keeps steering traffic. A single commit strobe then moves every staged cell into the active bank on the same clock edge, so all outputs switch over together. Both banks can be read back over the same bus. The output ports are split into equal groups, and each group has its own output-enable line.

Top module: `xbar_matrix`

## Requirements
- R1: After reset every cell in both banks is zero, every output port is 0, and reads of either bank return 0.
- R2: When output o's active cell has enable set (data bit IDX_W) and select s (data bits IDX_W-1:0), and its group is enabled, portOut[o] equals portIn[s] in the same cycle, for any s and whatever the other cells hold.
- R3: One input may be selected by several outputs at once, and each of those outputs follows it.
- R4: An output whose active cell has enable clear drives 0, whatever its select field and inputs hold.
- R5: A write to the shadow bank changes neither the active bank nor any output until a commit.
- R6: On a clock edge with commit high, every active cell takes its shadow value at that same edge.
- R7: If a commit and a shadow write land on the same edge, the active cell for the written index takes the newly written value.
- R8: A read (cfgRdEn) addresses output cfgAddr[IDX_W-1:0] in the shadow bank (cfgAddr[IDX_W]=0) or the active bank (cfgAddr[IDX_W]=1). The cell appears on cfgRdData one cycle later, with cfgRdValid high for that one cycle.
- R9: Writes with cfgAddr[IDX_W]=1 (active bank) are dropped and change no cell in either bank.
- R10: Output ports are split into GROUPS equal contiguous groups (group g holds outputs g*GROUP_SZ to g*GROUP_SZ+GROUP_SZ-1). While groupOutEn[g] is low the outputs in that group drive 0. Their routing is kept and takes effect again when the line returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgRdEn | input | 1 | Configuration read strobe |
| cfgAddr | input | IDX_W+1 | Bank select (MSB, 1 = active) and output index |
| cfgWrData | input | IDX_W+1 | Cell to write: enable in MSB, select below |
| commit | input | 1 | Global update: shadow bank copied to active bank |
| groupOutEn | input | GROUPS | Per-group output enable |
| portIn | input | PORTS | Crossbar inputs |
| portOut | output | PORTS | Crossbar outputs |
| cfgRdData | output | IDX_W+1 | Readback cell |
| cfgRdValid | output | 1 | Readback data valid |

## Verification
The bench stages routing and checks that outputs keep the old routing until the commit. A design that wrote straight to the live bank would switch outputs early. It also drives a write together with a commit and expects the fresh value to go live. A design that copied the shadow bank before the write would commit the stale cell. A write aimed at the active bank, a disabled cell with a non-zero select field, and a disabled group are each checked at the ports and through readback. These catch designs that let the write through, that leak the selected input, or that lose routing while the group is off. One input fanned out to many outputs and a full reversal permutation catch select decoding that blocks or aliases.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned PORTS    = 16;
  localparam int unsigned GROUPS   = 4;
  localparam int unsigned IDX_W    = $clog2(PORTS);
  localparam int unsigned CELL_W   = IDX_W + 1;
  localparam int unsigned GROUP_SZ = PORTS / GROUPS;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] sel;
  } cell_t;

  typedef struct packed {
    logic             wrShadow;
    logic             commit;
    logic             rdReq;
    logic             rdActive;
    logic [IDX_W-1:0] idx;
    cell_t            wrCell;
  } cfg_strobe_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [IDX_W:0]    cfgAddr,
  input  logic [CELL_W-1:0] cfgWrData,
  input  logic              commit,
  output cfg_strobe_t       stb
);
  logic bankIsActive;

  assign bankIsActive = cfgAddr[IDX_W];

  always_comb begin
    stb          = '0;
    stb.idx      = cfgAddr[IDX_W-1:0];
    stb.wrCell   = cell_t'(cfgWrData);
    // Only the staging bank is writable; active-bank writes are dropped (R9)
    stb.wrShadow = cfgWrEn && !bankIsActive;
    stb.commit   = commit;
    stb.rdReq    = cfgRdEn;
    stb.rdActive = bankIsActive;
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       stb,
  input  logic [PORTS-1:0]  portIn,
  input  logic [GROUPS-1:0] groupOutEn,
  output logic [PORTS-1:0]  portOut,
  output logic [CELL_W-1:0] rdData,
  output logic              rdValid
);
  cell_t [PORTS-1:0] shadowBank;
  cell_t [PORTS-1:0] activeBank;

  // Staging bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowBank <= '0;
    end else if (stb.wrShadow) begin
      shadowBank[stb.idx] <= stb.wrCell;
    end
  end

  // Live bank: whole-bank copy on commit, with same-edge write forwarded
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeBank <= '0;
    end else if (stb.commit) begin
      for (int o = 0; o < PORTS; o++) begin
        if (stb.wrShadow && (stb.idx == IDX_W'(o))) begin
          activeBank[o] <= stb.wrCell;
        end else begin
          activeBank[o] <= shadowBank[o];
        end
      end
    end
  end

  // Readback register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdReq;
      if (stb.rdReq) begin
        rdData <= stb.rdActive ? activeBank[stb.idx] : shadowBank[stb.idx];
      end
    end
  end

  // Per-output selection
  for (genvar o = 0; o < PORTS; o++) begin : g_out
    localparam int unsigned GRP = o / GROUP_SZ;
    logic picked;

    assign picked     = portIn[activeBank[o].sel];
    assign portOut[o] = groupOutEn[GRP] && activeBank[o].en && picked;

    AST_UNCONN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !activeBank[o].en |-> !portOut[o]); // R4
    AST_GROUP_OFF: assert property (@(posedge clk) disable iff (!rstN)
      !groupOutEn[GRP] |-> !portOut[o]); // R10
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrShadow |=> $stable(shadowBank)); // R9
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(activeBank)); // R5
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !stb.wrShadow) |=> (activeBank == $past(shadowBank))); // R6
  AST_COMMIT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && stb.wrShadow) |=> (activeBank[$past(stb.idx)] == $past(stb.wrCell))); // R7
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdReq |=> rdValid); // R8
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdReq |=> !rdValid); // R8
endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix
  import xbar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [IDX_W:0]    cfgAddr,
  input  logic [CELL_W-1:0] cfgWrData,
  input  logic              commit,
  input  logic [GROUPS-1:0] groupOutEn,
  input  logic [PORTS-1:0]  portIn,
  output logic [PORTS-1:0]  portOut,
  output logic [CELL_W-1:0] cfgRdData,
  output logic              cfgRdValid
);
  cfg_strobe_t stb;

  xbar_ctrl u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgRdEn   (cfgRdEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .commit    (commit),
    .stb       (stb)
  );

  xbar_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .portIn     (portIn),
    .groupOutEn (groupOutEn),
    .portOut    (portOut),
    .rdData     (cfgRdData),
    .rdValid    (cfgRdValid)
  );
endmodule

// File: tb/sim_xbar_matrix.sv
module sim_xbar_matrix;
  import xbar_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic              cfgRdEn = 1'b0;
  logic [IDX_W:0]    cfgAddr = '0;
  logic [CELL_W-1:0] cfgWrData = '0;
  logic              commit = 1'b0;
  logic [GROUPS-1:0] groupOutEn = '1;
  logic [PORTS-1:0]  portIn = '0;
  logic [PORTS-1:0]  portOut;
  logic [CELL_W-1:0] cfgRdData;
  logic              cfgRdValid;

  int nChecks = 0;
  int nFails  = 0;

  logic [CELL_W-1:0] shadowM [PORTS];
  logic [CELL_W-1:0] activeM [PORTS];
  logic [CELL_W-1:0] expQ [$];
  string             tagQ [$];

  always #5 clk = ~clk;

  xbar_matrix u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .commit(commit),
    .groupOutEn(groupOutEn), .portIn(portIn), .portOut(portOut),
    .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid)
  );

  function automatic logic [PORTS-1:0] expOut(logic [PORTS-1:0] din);
    logic [PORTS-1:0] r;
    for (int o = 0; o < PORTS; o++) begin
      r[o] = groupOutEn[o / GROUP_SZ] && activeM[o][IDX_W] && din[activeM[o][IDX_W-1:0]];
    end
    return r;
  endfunction

  task automatic report(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected readback cells as the design returns them
  always @(negedge clk) begin
    if (rstN && cfgRdValid) begin
      if (expQ.size() == 0) begin
        report("R8 unexpected read valid", 32'(cfgRdData), 32'hFFFF_FFFF);
      end else begin
        report(tagQ.pop_front(), 32'(cfgRdData), 32'(expQ.pop_front()));
      end
    end
  end

  task automatic cfgWrite(int idx, bit toActive, bit en, int sel, bit withCommit);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgAddr   = {toActive, IDX_W'(idx)};
    cfgWrData = {en, IDX_W'(sel)};
    commit    = withCommit;
    @(posedge clk);
    if (!toActive) shadowM[idx] = {en, IDX_W'(sel)};
    if (withCommit) for (int o = 0; o < PORTS; o++) activeM[o] = shadowM[o];
    @(negedge clk);
    cfgWrEn = 1'b0;
    commit  = 1'b0;
  endtask

  task automatic doCommit();
    @(negedge clk);
    commit = 1'b1;
    @(posedge clk);
    for (int o = 0; o < PORTS; o++) activeM[o] = shadowM[o];
    @(negedge clk);
    commit = 1'b0;
  endtask

  // Driver: issue a read and queue the value it must return
  task automatic readCell(int idx, bit fromActive, string tag);
    @(negedge clk);
    cfgRdEn = 1'b1;
    cfgAddr = {fromActive, IDX_W'(idx)};
    expQ.push_back(fromActive ? activeM[idx] : shadowM[idx]);
    tagQ.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    cfgRdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkPorts(logic [PORTS-1:0] din, string tag);
    @(negedge clk);
    portIn = din;
    #1;
    report(tag, 32'(portOut), 32'(expOut(din)));
  endtask

  task automatic sweep(string tag);
    checkPorts('1, tag);
    checkPorts(PORTS'(32'hA5A5_5A5A), tag);
    checkPorts(PORTS'(32'h0F0F_3C3C), tag);
    checkPorts('0, tag);
    for (int k = 0; k < PORTS; k += 3) checkPorts(PORTS'(1) << k, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int o = 0; o < PORTS; o++) begin
      shadowM[o] = '0;
      activeM[o] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    checkPorts('1, "R1 outputs after reset");
    readCell(0, 1'b1, "R1 active cell 0");
    readCell(5, 1'b0, "R1 shadow cell 5");
    readCell(PORTS - 1, 1'b1, "R1 active last cell");

    // R5: staging does not disturb live routing
    cfgWrite(0, 1'b0, 1'b1, 7, 1'b0);
    cfgWrite(5, 1'b0, 1'b1, 2, 1'b0);
    cfgWrite(PORTS - 1, 1'b0, 1'b1, 0, 1'b0);
    checkPorts('1, "R5 outputs before commit");
    readCell(5, 1'b1, "R5 active cell before commit");
    readCell(5, 1'b0, "R8 shadow readback");

    // R6 / R2: commit makes all staged routes live together
    doCommit();
    readCell(0, 1'b1, "R6 active cell 0 after commit");
    readCell(PORTS - 1, 1'b1, "R6 active last cell after commit");
    sweep("R2 routing after commit");

    // R3: fan-out from input 3
    cfgWrite(1, 1'b0, 1'b1, 3, 1'b0);
    cfgWrite(2, 1'b0, 1'b1, 3, 1'b0);
    cfgWrite(9, 1'b0, 1'b1, 3, 1'b0);
    cfgWrite(12, 1'b0, 1'b1, 3, 1'b0);
    doCommit();
    checkPorts(PORTS'(1) << 3, "R3 fan-out input high");
    checkPorts(~(PORTS'(1) << 3), "R3 fan-out input low");

    // R9: write aimed at the active bank is dropped
    cfgWrite(0, 1'b1, 1'b1, 9, 1'b0);
    readCell(0, 1'b1, "R9 active cell unchanged");
    readCell(0, 1'b0, "R9 shadow cell unchanged");
    doCommit();
    readCell(0, 1'b1, "R9 active cell after commit");
    checkPorts(PORTS'(1) << 7, "R9 outputs keep routing");

    // R4: disabled cell with non-zero select
    cfgWrite(5, 1'b0, 1'b0, 2, 1'b0);
    doCommit();
    checkPorts('1, "R4 disabled output");
    readCell(5, 1'b1, "R4 disabled cell readback");

    // R7: write and commit on the same edge
    cfgWrite(7, 1'b0, 1'b1, 11, 1'b1);
    readCell(7, 1'b1, "R7 same-edge commit readback");
    checkPorts(PORTS'(1) << 11, "R7 same-edge commit outputs");

    // R10: group gating keeps routing
    @(negedge clk);
    groupOutEn = 4'b1101;
    checkPorts('1, "R10 group 1 off");
    readCell(7, 1'b1, "R10 routing held while gated");
    @(negedge clk);
    groupOutEn = '1;
    checkPorts('1, "R10 group 1 back on");

    // R2: full reversal permutation
    for (int o = 0; o < PORTS; o++) cfgWrite(o, 1'b0, 1'b1, PORTS - 1 - o, 1'b0);
    doCommit();
    sweep("R2 reversal permutation");

    repeat (3) @(negedge clk);
    report("R8 readback queue drained", 32'(expQ.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule